// File: doc/BRIEF.md
# Free-Running Time Base with Compare Interrupt

This block keeps a wide count that advances by one on every clock after reset. It is intended as a shared time reference for several processors. Software can read the count at any time. One compare channel holds a 64-bit threshold. Once that channel is armed and the count has reached or passed the threshold, it latches a status flag. It drives a level interrupt from that flag unless the interrupt is masked. Software acknowledges the interrupt by disarming the channel, and then re-arms it with a new threshold.

Access goes through a plain 32-bit register port: an address, a write strobe, write data and combinational read data. Every access completes in one cycle. The port has no valid/ready handshake, because a register port carries no stream and so has nothing to back-pressure: a write takes effect at the clock edge where `bus_we` is high, and `bus_rdata` follows `bus_addr` within the same cycle. Because the count is wider than a word, software reads it as high word, then low word, then high word again, and it accepts the pair when the two high reads agree.

Top module: `sys_timebase`

## Requirements
- R1: After reset the count holds `CNT_INIT` (zero by default) and rises by exactly one on every clock edge while `rst_n` is high.
- R2: After the count reaches all ones across `CNT_W` bits, it continues from zero.
- R3: Address 0x8 reads count bits 31:0. Address 0xC reads count bits above 31, zero-extended to 32 bits. A carry out of the low word is visible in the high word on the next cycle.
- R4: Address 0x10020 holds threshold bits 31:0 and address 0x10024 holds threshold bits 63:32. Both can be written and read back, both reset to zero, and they change only when written.
- R5: Address 0x1002C is the channel control word: bit 0 arms the channel, bit 1 masks the interrupt, bit 2 is the status flag, and all other bits read zero. The word resets to zero.
- R6: While the channel is armed, the status flag is set at any clock edge where the threshold is less than or equal to the count, and it stays set while the channel remains armed.
- R7: The threshold is compared with the count zero-extended to 64 bits, so a threshold with a set bit at or above `CNT_W` never matches.
- R8: Writing the control word with bit 0 clear clears the status flag at that edge, and `irq` is low in the next cycle.
- R9: `irq` is high exactly when the channel is armed, the status flag is set and the mask is clear. While the mask is set, the status flag still updates.
- R10: Writing bit 2 of the control word has no effect on the status flag.
- R11: Reads of any other address return zero, and writes to other addresses have no effect. Writes to 0x8 or 0xC do not change the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 17 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, applied at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt from the compare channel |

## Verification
The bench builds two instances of the block. The first uses a 40-bit count that starts 256 ticks below 2^32. This puts the carry from the low word into the high word within the first few hundred cycles, so the bench checks every cycle around the carry and arms the channel against thresholds near the live count. The second uses a 12-bit count starting at zero. It wraps in 4096 cycles, so the bench can check every count value across a full wrap. On this instance the bench also checks the equality corner at the all-ones value and a threshold with bit 32 set that must never match.

// File: rtl/sysctr_pkg.sv
package sysctr_pkg;
  localparam int BUS_AW = 17;
  localparam int BUS_DW = 32;
  localparam int CMP_W  = 64;

  localparam logic [BUS_AW-1:0] OFS_CNT_LO = 17'h00008;
  localparam logic [BUS_AW-1:0] OFS_CNT_HI = 17'h0000C;
  localparam logic [BUS_AW-1:0] OFS_THR_LO = 17'h10020;
  localparam logic [BUS_AW-1:0] OFS_THR_HI = 17'h10024;
  localparam logic [BUS_AW-1:0] OFS_CTRL   = 17'h1002C;

  localparam int CTL_ARM  = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_FLAG = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_THR_LO,
    SEL_THR_HI,
    SEL_CTRL
  } rd_sel_e;

  typedef struct packed {
    logic thr_lo;
    logic thr_hi;
    logic ctrl;
  } wr_strobe_t;
endpackage

// File: rtl/tb_count_core.sv
module tb_count_core #(
  parameter int          CNT_W    = 56,
  parameter logic [63:0] CNT_INIT = 64'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] INIT_V = CNT_INIT[CNT_W-1:0];
  localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= INIT_V;
    else        count <= count + ONE_V;
  end

  // R1 / R2: one step per clock, modulo 2^CNT_W
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> count == $past(count) + ONE_V);
endmodule

// File: rtl/tb_reg_decode.sv
module tb_reg_decode
  import sysctr_pkg::*;
(
  input  logic [BUS_AW-1:0] addr,
  input  logic              we,
  output wr_strobe_t        wstb,
  output rd_sel_e           rsel
);
  always_comb begin
    rsel = SEL_NONE;
    unique case (addr)
      OFS_CNT_LO: rsel = SEL_CNT_LO;
      OFS_CNT_HI: rsel = SEL_CNT_HI;
      OFS_THR_LO: rsel = SEL_THR_LO;
      OFS_THR_HI: rsel = SEL_THR_HI;
      OFS_CTRL:   rsel = SEL_CTRL;
      default:    rsel = SEL_NONE;
    endcase
  end

  always_comb begin
    wstb.thr_lo = we && (rsel == SEL_THR_LO);
    wstb.thr_hi = we && (rsel == SEL_THR_HI);
    wstb.ctrl   = we && (rsel == SEL_CTRL);
  end
endmodule

// File: rtl/tb_cmp_channel.sv
module tb_cmp_channel
  import sysctr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wr_strobe_t        wstb,
  input  logic [BUS_DW-1:0] wdata,
  input  logic [CMP_W-1:0]  cnt_ext,
  output logic [CMP_W-1:0]  thr,
  output logic              arm,
  output logic              mask,
  output logic              flag,
  output logic              irq
);
  logic disarm_wr;
  assign disarm_wr = wstb.ctrl && !wdata[CTL_ARM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr  <= '0;
      arm  <= 1'b0;
      mask <= 1'b0;
    end else begin
      if (wstb.thr_lo) thr[31:0]  <= wdata;
      if (wstb.thr_hi) thr[63:32] <= wdata;
      if (wstb.ctrl) begin
        arm  <= wdata[CTL_ARM];
        mask <= wdata[CTL_MASK];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              flag <= 1'b0;
    else if (disarm_wr)      flag <= 1'b0;
    else if (!arm)           flag <= 1'b0;
    else if (thr <= cnt_ext) flag <= 1'b1;
  end

  assign irq = arm && flag && !mask;

  // R6: an armed match sets the flag at the next edge
  p_match_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !disarm_wr && thr <= cnt_ext) |=> flag);
  // R8: disarming clears the flag and silences irq
  p_disarm_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_wr |=> (!flag && !irq));
  // R4: the threshold moves only on its own write strobes
  p_thr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wstb.thr_lo || wstb.thr_hi) |=> $stable(thr));
endmodule

// File: rtl/sys_timebase.sv
module sys_timebase
  import sysctr_pkg::*;
#(
  parameter int          CNT_W    = 56,
  parameter logic [63:0] CNT_INIT = 64'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [16:0]       bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  logic [CNT_W-1:0] count;
  logic [CMP_W-1:0] cnt_ext;
  logic [CMP_W-1:0] thr;
  logic             arm, mask, flag;
  wr_strobe_t       wstb;
  rd_sel_e          rsel;

  tb_count_core #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_count (
    .clk(clk), .rst_n(rst_n), .count(count));

  generate
    if (CNT_W < CMP_W) begin : g_ext
      assign cnt_ext = {{(CMP_W-CNT_W){1'b0}}, count};
    end else begin : g_full
      assign cnt_ext = count[CMP_W-1:0];
    end
  endgenerate

  tb_reg_decode u_dec (
    .addr(bus_addr), .we(bus_we), .wstb(wstb), .rsel(rsel));

  tb_cmp_channel u_cmp (
    .clk(clk), .rst_n(rst_n), .wstb(wstb), .wdata(bus_wdata),
    .cnt_ext(cnt_ext), .thr(thr), .arm(arm), .mask(mask),
    .flag(flag), .irq(irq));

  always_comb begin
    bus_rdata = '0;
    unique case (rsel)
      SEL_CNT_LO: bus_rdata = cnt_ext[31:0];
      SEL_CNT_HI: bus_rdata = cnt_ext[63:32];
      SEL_THR_LO: bus_rdata = thr[31:0];
      SEL_THR_HI: bus_rdata = thr[63:32];
      SEL_CTRL: begin
        bus_rdata[CTL_ARM]  = arm;
        bus_rdata[CTL_MASK] = mask;
        bus_rdata[CTL_FLAG] = flag;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R9: while masked the interrupt stays low even as the flag is set
  p_mask_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && flag) |-> !irq);
endmodule

// File: tb/sim_sys_timebase.sv
`timescale 1ns/1ps
module sim_sys_timebase;
  localparam int          W0 = 40;
  localparam logic [63:0] I0 = 64'h0000_0000_FFFF_FF00;
  localparam int          W1 = 12;
  localparam logic [63:0] I1 = 64'd0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [16:0] addr = '0;
  logic [31:0] wdata = '0;
  logic we0 = 1'b0, we1 = 1'b0;
  logic [31:0] rd0, rd1;
  logic irq0, irq1;

  int n_chk = 0, n_bad = 0;
  longint unsigned ticks = 0;

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) ticks <= ticks + 1;

  sys_timebase #(.CNT_W(W0), .CNT_INIT(I0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we0),
    .bus_wdata(wdata), .bus_rdata(rd0), .irq(irq0));
  sys_timebase #(.CNT_W(W1), .CNT_INIT(I1)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we1),
    .bus_wdata(wdata), .bus_rdata(rd1), .irq(irq1));

  function automatic logic [63:0] model(input int w, input logic [63:0] init);
    logic [63:0] m;
    m = (64'd1 << w) - 64'd1;
    return (init + 64'(ticks)) & m;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input bit which, input logic [16:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    we0 = !which; we1 = which;
    @(negedge clk);
    we0 = 1'b0; we1 = 1'b0;
  endtask

  task automatic rd(input bit which, input logic [16:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = which ? rd1 : rd0;
  endtask

  task automatic run_all();
    logic [31:0] v, h, l;
    logic [63:0] thr, c;
    // reset state
    repeat (3) @(negedge clk);
    rd(0, 17'h8, v);       check("R1 reset count", v, I0[31:0]);
    rd(0, 17'h10020, v);   check("R4 reset thr lo", v, 0);
    rd(0, 17'h10024, v);   check("R4 reset thr hi", v, 0);
    rd(0, 17'h1002C, v);   check("R5 reset ctrl", v, 0);
    check("R9 reset irq", irq0, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R3: every cycle across the low-to-high carry
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      rd(0, 17'hC, h); rd(0, 17'h8, l);
      check("R3 count words", {h, l}, model(W0, I0));
    end
    rd(0, 17'hC, h); check("R3 carry in high word", h, 32'd1);

    // R11: count writes ignored
    wr(0, 17'h8, 32'h0); rd(0, 17'h8, v);
    check("R11 count lo write ignored", v, model(W0, I0) & 64'hFFFF_FFFF);
    wr(0, 17'hC, 32'h55); rd(0, 17'hC, v);
    check("R11 count hi write ignored", v, model(W0, I0) >> 32);

    // R4: threshold read back
    wr(0, 17'h10020, 32'hA5A5_1234); wr(0, 17'h10024, 32'h0000_00FF);
    rd(0, 17'h10020, v); check("R4 thr lo", v, 32'hA5A5_1234);
    rd(0, 17'h10024, v); check("R4 thr hi", v, 32'h0000_00FF);

    // R11: unmapped access
    wr(0, 17'h10028, 32'hFFFF_FFFF);
    rd(0, 17'h10028, v); check("R11 unmapped read", v, 0);
    rd(0, 17'h00004, v); check("R11 unmapped read low", v, 0);
    rd(0, 17'h10020, v); check("R11 unmapped write no effect", v, 32'hA5A5_1234);

    // R5 / R10: control field layout and read-only flag
    wr(0, 17'h1002C, 32'hFFFF_FFFA);
    rd(0, 17'h1002C, v); check("R5 ctrl fields", v, 32'h2);
    wr(0, 17'h1002C, 32'h4);
    rd(0, 17'h1002C, v); check("R10 flag write ignored", v, 0);
    check("R10 irq quiet", irq0, 0);

    // R6: threshold ahead of the count
    thr = model(W0, I0) + 64'd40;
    wr(0, 17'h10024, thr[63:32]); wr(0, 17'h10020, thr[31:0]);
    wr(0, 17'h1002C, 32'h1);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      c = model(W0, I0);
      check("R6 irq vs threshold", irq0, (c > thr) ? 1 : 0);
      rd(0, 17'h1002C, v);
      check("R6 flag bit", v[2], (c > thr) ? 1 : 0);
    end

    // R8: acknowledge by disarming
    wr(0, 17'h1002C, 32'h0);
    check("R8 irq after disarm", irq0, 0);
    rd(0, 17'h1002C, v); check("R8 flag after disarm", v, 0);

    // R9: masked channel still flags
    wr(0, 17'h10024, 32'h0); wr(0, 17'h10020, 32'h0);
    wr(0, 17'h1002C, 32'h3);
    repeat (3) @(negedge clk);
    check("R9 masked irq low", irq0, 0);
    rd(0, 17'h1002C, v); check("R9 flag while masked", v, 32'h7);
    wr(0, 17'h1002C, 32'h1);
    check("R9 unmask raises irq", irq0, 1);
    wr(0, 17'h1002C, 32'h0);
    check("R8 second ack", irq0, 0);

    // R7: threshold above count width never matches (12-bit instance)
    wr(1, 17'h10024, 32'h1); wr(1, 17'h10020, 32'h0);
    wr(1, 17'h1002C, 32'h1);
    // R2: every value across a full wrap
    for (int i = 0; i < 4200; i++) begin
      @(negedge clk);
      rd(1, 17'h8, l); rd(1, 17'hC, h);
      check("R2 wrap sweep", {h, l}, model(W1, I1));
      if (irq1 !== 1'b0) check("R7 no match above width", irq1, 0);
    end
    rd(1, 17'h1002C, v); check("R7 flag stays clear", v, 32'h1);
    wr(1, 17'h1002C, 32'h0);

    // R6 equality corner at all ones
    wr(1, 17'h10024, 32'h0); wr(1, 17'h10020, 32'hFFF);
    while (model(W1, I1) > 64'hF00 || model(W1, I1) < 64'h10) @(negedge clk);
    wr(1, 17'h1002C, 32'h1);
    while (model(W1, I1) != 64'hFFF) @(negedge clk);
    check("R6 no flag before equality", irq1, 0);
    @(negedge clk);
    check("R6 flag on equality", irq1, 1);
    repeat (20) @(negedge clk);
    check("R6 flag sticky after wrap", irq1, 1);
    wr(1, 17'h1002C, 32'h0);
    check("R8 ack small instance", irq1, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule